// File: doc/BRIEF.md
# Chunk Address Signature Conflict Detector

This block summarizes the memory footprint of one processor's current chunk of instructions. It keeps two hashed signatures, one for lines that were loaded and one for lines that were stored. Each signature is a bit vector in the style of a Bloom filter. When another processor commits a chunk, that processor's write signature arrives here. The block intersects it with both local signatures. A non-empty result squashes the local chunk.

The block also counts retired instructions. Once the configured chunk length is reached, it raises a commit request. When the request is granted, it hands its write signature to the commit fabric for one cycle and then starts a fresh, empty chunk.

Software can open and close the address-collection window. Accesses made while the window is closed leave no trace in either signature.

Top module: `sig_conflict_detector`

## Requirements
- R1: Each signature is 512 bits, made of 4 banks of 128 bits. Bank b occupies bits [128*b+127 : 128*b]. For an address, the line number is L = addr[31:6]. The bank b index is the XOR of all consecutive 7-bit groups of (L >> b), counted from bit 0, and an insertion sets that one bit in each bank.
- R2: A recorded load sets its bits in the read signature and a recorded store sets them in the write signature. Set bits stay set until the signatures are cleared, so the result does not depend on insertion order.
- R3: When `remote_valid` is high and the remote signature intersects the local read signature, `squash` is high in the following cycle.
- R4: The same happens when the remote signature intersects the local write signature.
- R5: Two signatures intersect only when, for every one of the 4 banks, the bitwise AND of that bank has at least one set bit.
- R6: A local access that arrives in the same cycle as a remote signature is inserted first, and the test sees it.
- R7: Collection is enabled after reset. `collect_end` disables it and `collect_begin` enables it, with end winning when both are high. Accesses made while collection is disabled are not recorded.
- R8: `commit_req` is high once `CHUNK_LEN` retirements have been counted in the chunk. It stays high until a grant or a squash, and further retirements while it is high are ignored.
- R9: A grant while `commit_req` is high makes `out_sig_valid` high for exactly the next cycle, with `out_sig` equal to the write signature. The edge after that cycle clears both signatures and the count. Accesses, retirements and remote signatures in that output cycle are ignored, and `out_sig` is zero whenever `out_sig_valid` is low.
- R10: `squash` is a one-cycle pulse. The same edge clears both signatures and the instruction count. A squash takes priority over a grant in the same cycle.
- R11: After reset, `squash`, `commit_req` and `out_sig_valid` are low, `out_sig` is zero, and both signatures are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | A local memory access this cycle |
| acc_is_store | input | 1 | 1 for a store, 0 for a load |
| acc_addr | input | 32 | Byte address of the access |
| instr_retire | input | 1 | One dynamic instruction retired |
| collect_begin | input | 1 | Open the address-collection window |
| collect_end | input | 1 | Close the address-collection window |
| remote_valid | input | 1 | A remote committed write signature is present |
| remote_sig | input | 512 | Remote committed write signature |
| commit_grant | input | 1 | Commit arbiter grants the pending request |
| commit_req | output | 1 | Chunk length reached, commit requested |
| out_sig_valid | output | 1 | Outgoing write signature valid strobe |
| out_sig | output | 512 | Outgoing write signature |
| squash | output | 1 | Local chunk squashed by a conflict |

## Verification
The signatures are not visible at the ports, so the bench exposes their contents in two ways: through the squash decision, and through the write signature that `out_sig` carries at each commit. A lost bit shows up as a missing squash on the next remote probe that covers it. A stray bit shows up as a false squash, or as a mismatch in `out_sig`, no later than the next commit. A wrong hash or a wrong bank placement shows up on the first probe. A miscounted chunk length shows up as `commit_req` rising one retirement early or late.

// File: rtl/sigdet_pkg.sv
package sigdet_pkg;
    localparam int ADDR_W   = 32;
    localparam int LINE_OFF = 6;
    localparam int NBANK    = 4;
    localparam int BANK_W   = 128;
    localparam int IDX_W    = $clog2(BANK_W);
    localparam int SIG_W    = NBANK * BANK_W;
    localparam int LINE_W   = ADDR_W - LINE_OFF;
    localparam int NFOLD    = (LINE_W + IDX_W - 1) / IDX_W;

    typedef logic [SIG_W-1:0]  sig_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LINE_W-1:0] line_t;

    typedef enum logic {PH_RUN, PH_EMIT} phase_e;

    typedef struct packed {
        logic  valid;
        logic  store;
        addr_t addr;
    } access_t;

    // Bank-specific XOR fold of the line number, shifted by the bank number
    function automatic logic [IDX_W-1:0] bank_index(addr_t a, int unsigned bank);
        line_t            line;
        line_t            part;
        logic [IDX_W-1:0] acc;
        line = line_t'(a[ADDR_W-1:LINE_OFF] >> bank);
        acc  = '0;
        for (int k = 0; k < NFOLD; k++) begin
            part = line >> (k * IDX_W);
            acc  = acc ^ part[IDX_W-1:0];
        end
        return acc;
    endfunction
endpackage

// File: rtl/sig_hash.sv
module sig_hash
    import sigdet_pkg::*;
(
    input  addr_t addr,
    output sig_t  bits
);
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [IDX_W-1:0] idx;
        assign idx = bank_index(addr, b);
        assign bits[b*BANK_W +: BANK_W] = {{(BANK_W-1){1'b0}}, 1'b1} << idx;
    end
endmodule

// File: rtl/sig_store.sv
module sig_store
    import sigdet_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic ins,
    input  sig_t bits,
    output sig_t sig,
    output sig_t sig_ins
);
    sig_t sig_q;

    assign sig_ins = sig_q | (ins ? bits : '0);
    assign sig     = sig_q;

    always_ff @(posedge clk) begin
        if (rst || clr) sig_q <= '0;
        else            sig_q <= sig_ins;
    end

    // R2: bits only accumulate inside a chunk
    p_bits_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((($past(sig_q)) & ~sig_q) == '0));
    // R10/R9: a clear empties the signature on the next edge
    p_clear_empty_r10: assert property (@(posedge clk) disable iff (rst)
        clr |=> (sig_q == '0));
endmodule

// File: rtl/sig_intersect.sv
module sig_intersect
    import sigdet_pkg::*;
(
    input  sig_t a,
    input  sig_t b,
    output logic hit
);
    logic [NBANK-1:0] bank_any;

    for (genvar k = 0; k < NBANK; k++) begin : g_bank
        assign bank_any[k] = |(a[k*BANK_W +: BANK_W] & b[k*BANK_W +: BANK_W]);
    end

    assign hit = &bank_any;
endmodule

// File: rtl/chunk_ctrl.sv
module chunk_ctrl #(
    parameter int CHUNK_LEN = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic retire,
    input  logic grant,
    input  logic conflict,
    output logic commit_req,
    output logic accept,
    output logic sig_clr,
    output logic running
);
    import sigdet_pkg::*;
    localparam int CNT_W = $clog2(CHUNK_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CHUNK_LEN);

    phase_e           phase;
    logic [CNT_W-1:0] count;

    assign running    = (phase == PH_RUN);
    assign commit_req = running && (count == CNT_MAX);
    assign accept     = commit_req && grant && !conflict;
    assign sig_clr    = conflict || (phase == PH_EMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_RUN;
            count <= '0;
        end else if (conflict) begin
            count <= '0;
        end else if (phase == PH_EMIT) begin
            phase <= PH_RUN;
            count <= '0;
        end else if (accept) begin
            phase <= PH_EMIT;
        end else if (retire && count < CNT_MAX) begin
            count <= count + 1'b1;
        end
    end

    p_count_cap_r8: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_MAX);
    p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (commit_req && !grant && !conflict) |=> commit_req);
    p_emit_single_r9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EMIT) |=> (phase == PH_RUN && count == '0));
endmodule

// File: rtl/sig_conflict_detector.sv
module sig_conflict_detector
    import sigdet_pkg::*;
#(
    parameter int CHUNK_LEN = 2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_is_store,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              instr_retire,
    input  logic              collect_begin,
    input  logic              collect_end,
    input  logic              remote_valid,
    input  logic [SIG_W-1:0]  remote_sig,
    input  logic              commit_grant,
    output logic              commit_req,
    output logic              out_sig_valid,
    output logic [SIG_W-1:0]  out_sig,
    output logic              squash
);
    access_t acc;
    logic    collecting;
    logic    running, accept, sig_clr, conflict;
    logic    rec, ins_rd, ins_wr, hit_rd, hit_wr;
    sig_t    acc_bits, rd_sig, rd_ins, wr_sig, wr_ins;
    sig_t    out_sig_q;
    logic    out_valid_q, squash_q;

    assign acc    = '{valid: acc_valid, store: acc_is_store, addr: acc_addr};
    assign rec    = acc.valid && collecting && running;
    assign ins_rd = rec && !acc.store;
    assign ins_wr = rec &&  acc.store;

    sig_hash u_hash (.addr(acc.addr), .bits(acc_bits));

    sig_store u_rd (.clk(clk), .rst(rst), .clr(sig_clr), .ins(ins_rd),
                    .bits(acc_bits), .sig(rd_sig), .sig_ins(rd_ins));
    sig_store u_wr (.clk(clk), .rst(rst), .clr(sig_clr), .ins(ins_wr),
                    .bits(acc_bits), .sig(wr_sig), .sig_ins(wr_ins));

    // Tests see the signatures with this cycle's access already inserted
    sig_intersect u_x_rd (.a(rd_ins), .b(remote_sig), .hit(hit_rd));
    sig_intersect u_x_wr (.a(wr_ins), .b(remote_sig), .hit(hit_wr));

    assign conflict = remote_valid && running && (hit_rd || hit_wr);

    chunk_ctrl #(.CHUNK_LEN(CHUNK_LEN)) u_ctrl (
        .clk(clk), .rst(rst), .retire(instr_retire), .grant(commit_grant),
        .conflict(conflict), .commit_req(commit_req), .accept(accept),
        .sig_clr(sig_clr), .running(running));

    always_ff @(posedge clk) begin
        if (rst) begin
            collecting  <= 1'b1;
            squash_q    <= 1'b0;
            out_valid_q <= 1'b0;
            out_sig_q   <= '0;
        end else begin
            if (collect_end)        collecting <= 1'b0;
            else if (collect_begin) collecting <= 1'b1;
            squash_q    <= conflict;
            out_valid_q <= accept;
            out_sig_q   <= accept ? wr_ins : '0;
        end
    end

    assign squash        = squash_q;
    assign out_sig_valid = out_valid_q;
    assign out_sig       = out_sig_q;

    p_squash_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        squash_q |=> !squash_q);
    p_squash_empty_r10: assert property (@(posedge clk) disable iff (rst)
        squash_q |-> (rd_sig == '0 && wr_sig == '0));
    p_strobe_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid_q |=> (!out_valid_q && rd_sig == '0 && wr_sig == '0));
    p_no_both_r10: assert property (@(posedge clk) disable iff (rst)
        !(squash_q && out_valid_q));
    p_sig_zero_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !out_valid_q |-> (out_sig_q == '0));
    p_window_closed_r7: assert property (@(posedge clk) disable iff (rst)
        (!collecting && !sig_clr) |=> (rd_sig == $past(rd_sig) && wr_sig == $past(wr_sig)));
endmodule

// File: tb/sig_conflict_detector_tb.sv
module sig_conflict_detector_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CL   = 8;
    localparam int SW   = 512;
    localparam int BW   = 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acc_valid = 0, acc_is_store = 0, instr_retire = 0;
    logic [31:0]   acc_addr = '0;
    logic          collect_begin = 0, collect_end = 0, remote_valid = 0, commit_grant = 0;
    logic [SW-1:0] remote_sig = '0;
    logic          commit_req, out_sig_valid, squash;
    logic [SW-1:0] out_sig;

    int tests = 0, fails = 0;
    bit done = 0;

    logic [SW-1:0] rd_m = '0, wr_m = '0;
    bit            coll_m = 1;
    int            cnt_m = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sig_conflict_detector #(.CHUNK_LEN(CL)) u_dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_is_store(acc_is_store),
        .acc_addr(acc_addr), .instr_retire(instr_retire), .collect_begin(collect_begin),
        .collect_end(collect_end), .remote_valid(remote_valid), .remote_sig(remote_sig),
        .commit_grant(commit_grant), .commit_req(commit_req), .out_sig_valid(out_sig_valid),
        .out_sig(out_sig), .squash(squash));

    // Hash per R1: line bits 31:6, shifted right by bank, folded into 7-bit groups
    function automatic logic [SW-1:0] hsig(logic [31:0] a);
        logic [SW-1:0] s = '0;
        for (int b = 0; b < 4; b++) begin
            int idx = 0;
            int line = int'(a >> 6) >>> b;
            for (int bit_i = 0; bit_i < 26; bit_i++)
                if ((line >> bit_i) & 1) idx = idx ^ (1 << (bit_i % 7));
            s[b*BW + idx] = 1'b1;
        end
        return s;
    endfunction

    // R5: every bank must share at least one set bit
    function automatic bit meets(logic [SW-1:0] x, logic [SW-1:0] y);
        bit all_hit = 1;
        for (int b = 0; b < 4; b++)
            if ((x[b*BW +: BW] & y[b*BW +: BW]) == '0) all_hit = 0;
        return all_hit;
    endfunction

    task automatic check(logic [SW-1:0] act, logic [SW-1:0] exp, string req);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic access(logic [31:0] a, bit st);
        acc_valid = 1; acc_is_store = st; acc_addr = a;
        cyc();
        acc_valid = 0;
        if (coll_m) begin
            if (st) wr_m |= hsig(a); else rd_m |= hsig(a);
        end
    endtask

    task automatic clear_m();
        rd_m = '0; wr_m = '0; cnt_m = 0;
    endtask

    // Remote probe, optionally with a simultaneous local access (R6)
    task automatic probe(logic [SW-1:0] s, bit with_acc, logic [31:0] a, bit st, string req);
        bit exp;
        if (with_acc && coll_m) begin
            if (st) wr_m |= hsig(a); else rd_m |= hsig(a);
        end
        exp = meets(s, rd_m) || meets(s, wr_m);
        remote_valid = 1; remote_sig = s;
        acc_valid = with_acc; acc_is_store = st; acc_addr = a;
        cyc();
        remote_valid = 0; acc_valid = 0;
        check(SW'(squash), SW'(exp), req);
        if (exp) clear_m();
        cyc();
        check(SW'(squash), '0, "R10 pulse");
    endtask

    task automatic retire_n(int n);
        for (int i = 0; i < n; i++) begin
            instr_retire = 1; cyc(); instr_retire = 0;
            if (cnt_m < CL) cnt_m++;
        end
        check(SW'(commit_req), SW'(cnt_m == CL), "R8 commit_req");
    endtask

    task automatic do_commit(string req);
        commit_grant = 1; cyc(); commit_grant = 0;
        check(SW'(out_sig_valid), SW'(1), req);
        check(out_sig, wr_m, req);
        cyc();
        check(SW'(out_sig_valid), '0, "R9 strobe one cycle");
        check(out_sig, '0, "R9 out_sig idle zero");
        clear_m();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [SW-1:0] s1, s2;
        repeat (3) cyc();
        rst = 0;
        // R11
        check(SW'(squash), '0, "R11 squash");
        check(SW'(commit_req), '0, "R11 commit_req");
        check(SW'(out_sig_valid), '0, "R11 valid");
        check(out_sig, '0, "R11 out_sig");
        probe(hsig(32'h40), 0, 0, 0, "R11 empty no squash");

        // R3 read conflict, R4 write conflict
        access(32'h0000_1000, 0);
        probe(hsig(32'h0000_1000), 0, 0, 0, "R3 read conflict");
        access(32'h0000_2040, 1);
        probe(hsig(32'h0000_2040), 0, 0, 0, "R4 write conflict");
        // R1 same line, different byte offset
        access(32'h0000_3000, 0);
        probe(hsig(32'h0000_303F), 0, 0, 0, "R1 same line");

        // R5: one bank empty in the AND
        access(32'h0000_5000, 1);
        s1 = hsig(32'h0000_5000); s1[3*BW +: BW] = '0;
        probe(s1, 0, 0, 0, "R5 bank missing");
        s1 = hsig(32'h0000_5000) | hsig(32'h0001_7000);
        probe(s1, 0, 0, 0, "R5 full hit");

        // R6 same-cycle insertion
        probe(hsig(32'h0000_9AC0), 1, 32'h0000_9AC0, 0, "R6 same cycle load");
        probe(hsig(32'h0000_7700), 1, 32'h0000_7700, 1, "R6 same cycle store");

        // R7 window
        collect_end = 1; cyc(); collect_end = 0; coll_m = 0;
        access(32'h0000_4440, 0);
        access(32'h0000_4480, 1);
        probe(hsig(32'h0000_4440) | hsig(32'h0000_4480), 0, 0, 0, "R7 closed ignored");
        collect_end = 1; collect_begin = 1; cyc(); collect_end = 0; collect_begin = 0;
        access(32'h0000_4440, 0);
        probe(hsig(32'h0000_4440), 0, 0, 0, "R7 end wins");
        collect_begin = 1; cyc(); collect_begin = 0; coll_m = 1;
        access(32'h0000_4440, 0);
        probe(hsig(32'h0000_4440), 0, 0, 0, "R7 reopened");

        // R8/R9 commit and order independence (R2)
        access(32'h0000_A000, 1); access(32'h0001_B040, 1); access(32'h0002_C080, 0);
        retire_n(CL - 1);
        retire_n(1);
        retire_n(3);
        do_commit("R9 emit A-B");
        s2 = out_sig;
        access(32'h0001_B040, 1); access(32'h0000_A000, 1);
        retire_n(CL);
        commit_grant = 1; cyc(); commit_grant = 0;
        check(out_sig, hsig(32'h0000_A000) | hsig(32'h0001_B040), "R2 order independent");
        cyc(); clear_m();
        retire_n(CL - 1);
        retire_n(1);
        // R9 inputs ignored during output cycle
        access(32'h0000_D000, 1);
        commit_grant = 1; cyc(); commit_grant = 0;
        check(SW'(out_sig_valid), SW'(1), "R9 strobe");
        remote_valid = 1; remote_sig = hsig(32'h0000_D000);
        acc_valid = 1; acc_is_store = 0; acc_addr = 32'h0000_E000; instr_retire = 1;
        cyc();
        remote_valid = 0; acc_valid = 0; instr_retire = 0;
        check(SW'(squash), '0, "R9 remote ignored");
        clear_m();
        probe(hsig(32'h0000_D000) | hsig(32'h0000_E000), 0, 0, 0, "R9 cleared");
        retire_n(CL - 1);

        // R10 squash resets count; priority over grant
        clear_m();
        access(32'h0000_F000, 0);
        probe(hsig(32'h0000_F000), 0, 0, 0, "R10 squash");
        check(SW'(commit_req), '0, "R10 count reset");
        retire_n(CL - 1);
        retire_n(1);
        access(32'h0001_0000, 1);
        remote_valid = 1; remote_sig = hsig(32'h0001_0000); commit_grant = 1;
        cyc();
        remote_valid = 0; commit_grant = 0;
        check(SW'(squash), SW'(1), "R10 priority squash");
        check(SW'(out_sig_valid), '0, "R10 grant dropped");
        check(SW'(commit_req), '0, "R10 req dropped");
        clear_m();
        cyc();

        // Sweep: mixed accesses with probes against the model (R2-R5)
        for (int i = 0; i < 60; i++) begin
            logic [31:0] a = 32'(i * 64 * 37 + (i % 5) * 4096);
            access(a, (i % 3) == 1);
            if (i % 4 == 3) begin
                logic [31:0] p = (i % 8 == 3) ? a : 32'(a + 64 * 101);
                probe(hsig(p), 0, 0, 0, "R3 R4 sweep");
            end
            if (i % 10 == 9) begin
                retire_n(CL);
                do_commit("R9 sweep commit");
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule